// File: doc/BRIEF.md
# Palette RAMDAC with Pixel Conversion

This block is a colour lookup table for an indexed frame buffer. Software programs it through a small word-spaced register window on a 32-bit write bus. One register sets the entry pointer. A second register takes the red, green and blue components of that entry on three successive writes. After the blue write the pointer moves to the next entry, so a whole palette can be loaded with a single pointer write followed by a stream of component writes.

On the display side, an 8-bit pixel index selects one entry. The block returns that entry's colour repacked into the format the downstream pixel path needs: 3-3-2 in 8 bits, 5-5-5 in 15 bits, 5-6-5 in 16 bits, or 8-8-8 in 32 bits. The three wider formats can swap the red and blue fields. A one-cycle pulse follows every component write, so that display logic knows the picture has to be redrawn.

Top module: `pal_ramdac`

## Requirements
- R1: After reset, `pix_out` is 0, `pal_update` is 0, the entry pointer is 0, the component step is red, and every component of every entry reads as 0.
- R2: The register select is `(bus_addr & (REG_WIN-1)) >> 2`, with a default window of 16 bytes. Select 0 is the pointer register and select 1 is the component register. Address bits above the window are ignored, so address 0x10 acts as select 0 and 0x14 acts as select 1.
- R3: A write to select 0 loads the entry pointer from `bus_wdata[31:24]` and returns the component step to red, including when the step is partway through an entry.
- R4: Successive writes to select 1 store `bus_wdata[31:24]` into the red component of the pointed entry, then its green component, then its blue component.
- R5: After the blue write, the pointer increments modulo 256 (255 wraps to 0) and the step returns to red.
- R6: Writes to select 2 or 3 change no palette entry, the pointer or the step, and do not raise `pal_update`.
- R7: `pix_out` is registered. It shows the entry addressed by `pix_idx`, packed in the `pix_fmt`/`pix_bgr` mode of the same cycle, one clock later. A component write and a lookup of the same entry in the same cycle return the colour from before the write.
- R8: With `pix_fmt`=0 (8-bit), `pix_out[7:5]`=red[7:5], `pix_out[4:2]`=green[7:5], `pix_out[1:0]`=blue[7:6], the upper bits are 0, and `pix_bgr` has no effect.
- R9: With `pix_fmt`=1 (15-bit), `pix_out[14:10]`=red[7:3], `pix_out[9:5]`=green[7:3] and `pix_out[4:0]`=blue[7:3], and the upper bits are 0. `pix_bgr`=1 swaps the red and blue fields.
- R10: With `pix_fmt`=2 (16-bit), `pix_out[15:11]`=red[7:3], `pix_out[10:5]`=green[7:2] and `pix_out[4:0]`=blue[7:3], and the upper bits are 0. `pix_bgr`=1 swaps the red and blue fields.
- R11: With `pix_fmt`=3 (32-bit), `pix_out[23:16]`=red, `pix_out[15:8]`=green and `pix_out[7:0]`=blue, and `pix_out[31:24]` is 0. `pix_bgr`=1 swaps the red and blue fields.
- R12: `pal_update` is high for exactly the one cycle after each write to select 1, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| pix_idx | input | 8 | Pixel index to look up |
| pix_fmt | input | 2 | Output format: 0 = 8-bit, 1 = 15-bit, 2 = 16-bit, 3 = 32-bit |
| pix_bgr | input | 1 | Swap red and blue in the 15-, 16- and 32-bit formats |
| pix_out | output | 32 | Packed colour, one cycle after the lookup |
| pal_update | output | 1 | One-cycle pulse after each component write |

## Verification
The pointer and the step counter are never visible at the ports. A bench can only infer them from where later component writes land. The hardest cases are a pointer rewrite in the middle of an entry, a wrap from entry 255 to entry 0, and writes to the unused selects between component writes. Each case is staged as a short scripted write sequence and then followed by lookups of the neighbouring entries, which must show the component values in the right places. A full palette load and a sweep over every entry in all eight format and order combinations then compare each lookup against arithmetic packing done in the bench.

// File: rtl/pal_pkg.sv
package pal_pkg;

    localparam int COMP_W   = 8;
    localparam int NUM_COMP = 3;
    localparam int OUT_W    = 32;

    typedef enum logic [1:0] {
        FMT_332 = 2'd0,
        FMT_555 = 2'd1,
        FMT_565 = 2'd2,
        FMT_888 = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        STEP_RED   = 2'd0,
        STEP_GREEN = 2'd1,
        STEP_BLUE  = 2'd2,
        STEP_BAD   = 2'd3
    } step_e;

    typedef struct packed {
        logic [COMP_W-1:0] red;
        logic [COMP_W-1:0] green;
        logic [COMP_W-1:0] blue;
    } color_t;

    function automatic logic [OUT_W-1:0] pack_pixel(color_t c, fmt_e f, logic swap);
        logic [COMP_W-1:0] hi;
        logic [COMP_W-1:0] lo;
        logic [OUT_W-1:0]  res;
        hi = swap ? c.blue : c.red;
        lo = swap ? c.red  : c.blue;
        case (f)
            FMT_332: res = {24'd0, c.red[7:5], c.green[7:5], c.blue[7:6]};
            FMT_555: res = {17'd0, hi[7:3], c.green[7:3], lo[7:3]};
            FMT_565: res = {16'd0, hi[7:3], c.green[7:2], lo[7:3]};
            default: res = {8'd0, hi, c.green, lo};
        endcase
        return res;
    endfunction

endpackage

// File: rtl/pal_regif.sv
module pal_regif
    import pal_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter int REG_WIN = 16,
    parameter int IDX_W   = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [NUM_COMP-1:0] comp_we,
    output logic [IDX_W-1:0]    cur_idx,
    output logic [COMP_W-1:0]   comp_val,
    output step_e               cur_step,
    output logic                upd_pulse
);

    localparam logic [ADDR_W-1:0] WIN_MASK = ADDR_W'(REG_WIN - 1);

    logic [ADDR_W-1:0] sel;
    logic              hit_ptr;
    logic              hit_col;

    always_comb begin
        sel     = (bus_addr & WIN_MASK) >> 2;
        hit_ptr = bus_wr && (sel == '0);
        hit_col = bus_wr && (sel == ADDR_W'(1));
        comp_val = bus_wdata[DATA_W-1 -: COMP_W];
    end

    genvar k;
    generate
        for (k = 0; k < NUM_COMP; k++) begin : g_we
            always_comb comp_we[k] = hit_col && (cur_step == step_e'(k));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_idx   <= '0;
            cur_step  <= STEP_RED;
            upd_pulse <= 1'b0;
        end else begin
            upd_pulse <= hit_col;
            if (hit_ptr) begin
                cur_idx  <= bus_wdata[DATA_W-1 -: IDX_W];
                cur_step <= STEP_RED;
            end else if (hit_col) begin
                case (cur_step)
                    STEP_RED:   cur_step <= STEP_GREEN;
                    STEP_GREEN: cur_step <= STEP_BLUE;
                    STEP_BLUE: begin
                        cur_step <= STEP_RED;
                        cur_idx  <= cur_idx + 1'b1;
                    end
                    default:    cur_step <= STEP_RED;
                endcase
            end
        end
    end

endmodule

// File: rtl/pal_store.sv
module pal_store
    import pal_pkg::*;
#(
    parameter int ENTRIES = 256,
    parameter int IDX_W   = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_COMP-1:0] comp_we,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [COMP_W-1:0]   wr_val,
    input  logic [IDX_W-1:0]    rd_idx,
    output color_t              rd_color
);

    logic [COMP_W-1:0] rd_comp [NUM_COMP];

    genvar k;
    generate
        for (k = 0; k < NUM_COMP; k++) begin : g_plane
            logic [COMP_W-1:0] mem [ENTRIES];

            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
                end else if (comp_we[k]) begin
                    mem[wr_idx] <= wr_val;
                end
            end

            always_comb rd_comp[k] = mem[rd_idx];
        end
    endgenerate

    always_comb begin
        rd_color.red   = rd_comp[0];
        rd_color.green = rd_comp[1];
        rd_color.blue  = rd_comp[2];
    end

endmodule

// File: rtl/pal_pack.sv
module pal_pack
    import pal_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  color_t           color,
    input  logic [1:0]       fmt,
    input  logic             swap,
    output logic [OUT_W-1:0] pix_out
);

    always_ff @(posedge clk) begin
        if (rst) pix_out <= '0;
        else     pix_out <= pack_pixel(color, fmt_e'(fmt), swap);
    end

endmodule

// File: rtl/pal_ramdac.sv
module pal_ramdac
    import pal_pkg::*;
#(
    parameter int ENTRIES = 256,
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter int REG_WIN = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [7:0]        pix_idx,
    input  logic [1:0]        pix_fmt,
    input  logic              pix_bgr,
    output logic [31:0]       pix_out,
    output logic              pal_update
);

    localparam int IDX_W = $clog2(ENTRIES);

    logic [NUM_COMP-1:0] comp_we;
    logic [IDX_W-1:0]    cur_idx;
    logic [COMP_W-1:0]   comp_val;
    step_e               cur_step;
    color_t              look_color;
    logic                unused_wdata;

    assign unused_wdata = ^bus_wdata[DATA_W-COMP_W-1:0];

    pal_regif #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .REG_WIN(REG_WIN),
        .IDX_W  (IDX_W)
    ) i_regif (
        .clk      (clk),
        .rst      (rst),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .comp_we  (comp_we),
        .cur_idx  (cur_idx),
        .comp_val (comp_val),
        .cur_step (cur_step),
        .upd_pulse(pal_update)
    );

    pal_store #(
        .ENTRIES(ENTRIES),
        .IDX_W  (IDX_W)
    ) i_store (
        .clk     (clk),
        .rst     (rst),
        .comp_we (comp_we),
        .wr_idx  (cur_idx),
        .wr_val  (comp_val),
        .rd_idx  (pix_idx[IDX_W-1:0]),
        .rd_color(look_color)
    );

    pal_pack i_pack (
        .clk    (clk),
        .rst    (rst),
        .color  (look_color),
        .fmt    (pix_fmt),
        .swap   (pix_bgr),
        .pix_out(pix_out)
    );

endmodule

// File: rtl/pal_ramdac_chk.sv
module pal_ramdac_chk #(
    parameter int ADDR_W  = 12,
    parameter int REG_WIN = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [1:0]        pix_fmt,
    input logic [31:0]       pix_out,
    input logic              pal_update,
    input logic [7:0]        idx,
    input logic [1:0]        step
);

    logic [ADDR_W-1:0] sel;
    assign sel = (bus_addr & ADDR_W'(REG_WIN - 1)) >> 2;

    AST_PTR_LOAD: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel == 0) |=> (idx == $past(bus_wdata[31:24]) && step == 2'd0)); // R3

    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel == 1 && step != 2'd2) |=> (step == $past(step) + 2'd1 && $stable(idx))); // R4

    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel == 1 && step == 2'd2) |=> (idx == $past(idx) + 8'd1 && step == 2'd0)); // R5

    AST_IGNORED_SEL: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel > 1) |=> ($stable(idx) && $stable(step) && !pal_update)); // R6

    AST_UPDATE_PULSE: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel == 1) |=> pal_update); // R12

    AST_NO_SPURIOUS_UPDATE: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && sel == 1) |=> !pal_update); // R12

    AST_FMT8_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (pix_fmt == 2'd0) |=> (pix_out[31:8] == 24'd0)); // R8

    AST_FMT32_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (pix_fmt == 2'd3) |=> (pix_out[31:24] == 8'd0)); // R11

endmodule

bind pal_ramdac pal_ramdac_chk #(
    .ADDR_W (ADDR_W),
    .REG_WIN(REG_WIN)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pix_fmt   (pix_fmt),
    .pix_out   (pix_out),
    .pal_update(pal_update),
    .idx       (cur_idx),
    .step      (cur_step)
);

// File: tb/test_pal_ramdac.sv
`timescale 1ns/1ps
module test_pal_ramdac;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [7:0]  pix_idx = '0;
    logic [1:0]  pix_fmt = '0;
    logic        pix_bgr = 1'b0;
    logic [31:0] pix_out;
    logic        pal_update;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    int mr [256];
    int mg [256];
    int mb [256];

    always #4 clk = ~clk;

    pal_ramdac i_pal_ramdac (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .pix_idx(pix_idx), .pix_fmt(pix_fmt),
        .pix_bgr(pix_bgr), .pix_out(pix_out), .pal_update(pal_update)
    );

    function automatic int expect_pix(int r, int g, int b, int f, int sw);
        int hi;
        int lo;
        hi = sw ? b : r;
        lo = sw ? r : b;
        case (f)
            0: return (r / 32) * 32 + (g / 32) * 4 + b / 64;
            1: return (hi / 8) * 1024 + (g / 8) * 32 + lo / 8;
            2: return (hi / 8) * 2048 + (g / 4) * 32 + lo / 8;
            default: return hi * 65536 + g * 256 + lo;
        endcase
    endfunction

    task automatic check(string req, longint got, longint exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic bus_write(int addr, int val);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_addr = addr[11:0];
        bus_wdata = {val[7:0], 24'h00A5C3};
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic lookup(int idx, int f, int sw, output int got);
        @(negedge clk);
        pix_idx = idx[7:0];
        pix_fmt = f[1:0];
        pix_bgr = sw[0];
        @(negedge clk);
        got = int'(pix_out);
    endtask

    task automatic check_entry(string req, int idx);
        int got;
        lookup(idx, 3, 0, got);
        check(req, got, expect_pix(mr[idx], mg[idx], mb[idx], 3, 0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int got;
        for (int i = 0; i < 256; i++) begin mr[i] = 0; mg[i] = 0; mb[i] = 0; end
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1 pix_out at reset", pix_out, 0);
        check("R1 pal_update at reset", pal_update, 0);
        rst = 1'b0;
        for (int i = 0; i < 256; i++) check_entry("R1 entry zero", i);

        // R4 R5 R12: full load through auto-increment
        bus_write(0, 0);
        for (int i = 0; i < 256; i++) begin
            mr[i] = i; mg[i] = i ^ 8'hA5; mb[i] = 255 - i;
            bus_write(4, mr[i]);
            if (i == 0) check("R12 pulse after write", pal_update, 1);
            bus_write(4, mg[i]);
            bus_write(4, mb[i]);
        end
        @(negedge clk);
        check("R12 pulse ends", pal_update, 0);

        // R7 R8 R9 R10 R11: every entry in every format and order
        for (int f = 0; f < 4; f++)
            for (int sw = 0; sw < 2; sw++)
                for (int i = 0; i < 256; i++) begin
                    lookup(i, f, sw, got);
                    case (f)
                        0: check("R8 fmt 3-3-2", got, expect_pix(mr[i], mg[i], mb[i], f, sw));
                        1: check("R9 fmt 5-5-5", got, expect_pix(mr[i], mg[i], mb[i], f, sw));
                        2: check("R10 fmt 5-6-5", got, expect_pix(mr[i], mg[i], mb[i], f, sw));
                        default: check("R11 fmt 8-8-8", got, expect_pix(mr[i], mg[i], mb[i], f, sw));
                    endcase
                end

        // R3: pointer rewrite mid-entry restarts at red
        bus_write(0, 30);
        bus_write(4, 1);
        bus_write(4, 2);
        bus_write(0, 30);
        bus_write(4, 3);
        bus_write(4, 4);
        bus_write(4, 5);
        mr[30] = 3; mg[30] = 4; mb[30] = 5;
        check_entry("R3 restart entry 30", 30);
        check_entry("R3 entry 31 untouched", 31);

        // R6: unused selects ignored between component writes
        bus_write(0, 10);
        bus_write(4, 8'h11);
        bus_write(8, 8'hFF);
        check("R6 no pulse on select 2", pal_update, 0);
        bus_write(12, 8'hEE);
        check("R6 no pulse on select 3", pal_update, 0);
        bus_write(4, 8'h22);
        bus_write(4, 8'h33);
        mr[10] = 8'h11; mg[10] = 8'h22; mb[10] = 8'h33;
        check_entry("R6 entry 10 sequence intact", 10);
        check_entry("R6 entry 11 untouched", 11);

        // R2: aliases above the window
        bus_write(12'h010, 20);
        bus_write(12'h014, 8'h44);
        bus_write(12'h034, 8'h55);
        bus_write(12'hFF4, 8'h66);
        mr[20] = 8'h44; mg[20] = 8'h55; mb[20] = 8'h66;
        check_entry("R2 aliased select", 20);

        // R5: wrap from 255 to 0
        bus_write(0, 255);
        bus_write(4, 7); bus_write(4, 8); bus_write(4, 9);
        bus_write(4, 10); bus_write(4, 11); bus_write(4, 12);
        mr[255] = 7; mg[255] = 8; mb[255] = 9;
        mr[0] = 10; mg[0] = 11; mb[0] = 12;
        check_entry("R5 entry 255", 255);
        check_entry("R5 wrap to entry 0", 0);

        // R7: same-cycle write and lookup returns old colour
        bus_write(0, 50);
        @(negedge clk);
        pix_idx = 8'd50; pix_fmt = 2'd3; pix_bgr = 1'b0;
        bus_wr = 1'b1; bus_addr = 12'h004; bus_wdata = 32'h9A000000;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R7 old colour on collision", pix_out, expect_pix(mr[50], mg[50], mb[50], 3, 0));
        check("R12 pulse on collision write", pal_update, 1);
        mr[50] = 8'h9A;
        @(negedge clk);
        check("R7 new colour next cycle", pix_out, expect_pix(mr[50], mg[50], mb[50], 3, 0));

        // R1: reset again clears the palette and pointer
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 256; i++) begin mr[i] = 0; mg[i] = 0; mb[i] = 0; end
        check_entry("R1 entry 20 cleared", 20);
        bus_write(4, 8'h77);
        mr[0] = 8'h77;
        check_entry("R1 pointer cleared", 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule